// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block runs whole transactions against a two-wire serial EEPROM on behalf of a client. It accepts one request at a time: write a run of bytes starting at a word address, read a run of bytes starting at a given word address, or read a run of bytes from wherever the memory's own address pointer stands. It breaks each request into a sequence of bus commands for a byte engine below it. The byte engine generates start and stop conditions, shifts one byte out and returns the acknowledge it sees, or shifts one byte in and drives the acknowledge bit the sequencer asks for.

Each transaction begins with a control byte. This byte holds the fixed memory device-type code, the chip-select bits, the high word-address bits that pick a 256-byte block, and the direction bit. A write sends the control byte, the low word address and the data bytes, and then a stop. After a write that succeeds, the block refuses new requests until the memory's internal programming time has elapsed. An addressed read first sets the memory's pointer with a write-direction control byte and the word address. It then issues a repeated start, sends the read-direction control byte and clocks in the bytes, refusing acknowledge on the last one. If the slave fails to acknowledge any byte, the block sends a stop and reports an error code. If bus arbitration is lost, the block stops driving the bus at once and reports that as well.

Top module: `eeseq_top`

## Requirements
- R1: The control byte has 1010 in bits 7:4, the upper chip-select bits `req_chip` next, and then word-address bits ADDR_W-1:8 down to bit 1. Bit 0 is 0 for write direction and 1 for read direction.
- R2: A write request (`req_op`=0) produces, in order, START, a write-direction control byte, `req_addr[7:0]`, `req_len`+1 data bytes and STOP. Engine command codes are 0 START, 1 WRITE, 2 READ and 3 STOP. The data bytes are taken from `wr_data`, and one `wr_pop` pulse is given per byte as it is issued.
- R3: An addressed read (`req_op`=2 or 3) produces, in order, START, a write-direction control byte, the low word address, a second START, a read-direction control byte, `req_len`+1 READ commands and STOP. Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in order.
- R4: A current-address read (`req_op`=1) produces START, a read-direction control byte, the READ commands and STOP. It sends no word address and no second START.
- R5: `eng_last` (master NACK) is 1 on the final READ of a transaction and 0 on every earlier READ.
- R6: A missing acknowledge on the control byte, the word address or a data byte ends the transaction. The block issues STOP and no further byte, then gives a one-cycle `done` with `err` set to 1, 2 or 3 for those cases. A transaction that completes gives `err`=0.
- R7: If `eng_arb_lost` accompanies a command's completion, the block issues no further command, not even STOP, and gives `done` with `err`=4. A byte whose read lost arbitration is not delivered.
- R8: After a write that completes without error, `req_ready` stays low for at least WAIT_CYCLES cycles after `done`. After a read, or after a write that failed, `req_ready` returns on the cycle after `done`.
- R9: Coming out of reset, `req_ready` is 1 and `eng_cmd_valid`, `done` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 0 write, 1 current-address read, 2/3 addressed read |
| req_addr | input | ADDR_W | Word address; bits above 7 select the 256-byte block |
| req_len | input | LEN_W | Byte count minus one |
| req_chip | input | CHIP_W | Chip-select bits placed in the control byte |
| wr_data | input | 8 | Head of the client's write-data FIFO |
| wr_pop | output | 1 | Consume the FIFO head |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid for one cycle |
| done | output | 1 | Transaction finished (one cycle) |
| err | output | 3 | Result code, valid with `done` |
| eng_cmd_valid | output | 1 | Command issued to byte engine (one cycle) |
| eng_cmd | output | 2 | Command code |
| eng_tx | output | 8 | Byte to send for WRITE |
| eng_last | output | 1 | For READ: answer with NACK |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Slave did not acknowledge the sent byte |
| eng_arb_lost | input | 1 | Arbitration lost during the command |
| eng_rx | input | 8 | Byte received by READ |

## Verification
The stimulus covers a multi-byte page write, a single-byte write, addressed reads of one, four and sixteen bytes, and a current-address read. Together these separate the three command sequences and show that the NACK falls only on the final read, including when that read is also the first. Missing acknowledges are placed on the control byte, the word address and the second data byte. This shows which error code each position gives and confirms that nothing follows the STOP, counted both in engine commands and in FIFO pops. Arbitration loss is placed once on a write's control byte and once on a read data byte. The ready gap after each transaction shows that only a successful write waits out the programming time.

// File: rtl/eeseq_pkg.sv
// Shared codes for the serial EEPROM transaction sequencer.
// Assumes: the byte engine understands the four command codes below.
package eeseq_pkg;
    localparam logic [1:0] CMD_START = 2'd0;
    localparam logic [1:0] CMD_WRITE = 2'd1;
    localparam logic [1:0] CMD_READ  = 2'd2;
    localparam logic [1:0] CMD_STOP  = 2'd3;

    localparam logic [1:0] OP_WRITE    = 2'd0;
    localparam logic [1:0] OP_READ_CUR = 2'd1;

    localparam logic [2:0] ERR_NONE       = 3'd0;
    localparam logic [2:0] ERR_NACK_CTRL  = 3'd1;
    localparam logic [2:0] ERR_NACK_WADDR = 3'd2;
    localparam logic [2:0] ERR_NACK_DATA  = 3'd3;
    localparam logic [2:0] ERR_ARB        = 3'd4;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_CTRL_W, S_WADDR, S_WDATA, S_RSTART,
        S_CTRL_R, S_RDATA, S_STOP, S_FIN, S_WAIT
    } seq_state_t;
endpackage

// File: rtl/eeseq_ctrl.sv
// Builds the write- and read-direction control bytes from the device type,
// chip-select bits and block-select address bits.
// Assumes: CHIP_W + BLK_W == 3 and both are at least 1.
module eeseq_ctrl #(
    parameter int CHIP_W = 1,
    parameter int BLK_W  = 2
) (
    input  logic [CHIP_W-1:0] chip,
    input  logic [BLK_W-1:0]  blk,
    output logic [7:0]        ctrl_wr,
    output logic [7:0]        ctrl_rd
);
    import eeseq_pkg::*;

    // Concatenate the fixed type code, select bits and direction bit.
    always_comb begin
        ctrl_wr = {DEV_TYPE, chip, blk, 1'b0};
        ctrl_rd = {DEV_TYPE, chip, blk, 1'b1};
    end
endmodule

// File: rtl/eeseq_cnt.sv
// Remaining-byte counter: loaded with count-minus-one, decremented per byte.
// Assumes: dec is never asserted while the counter reads zero.
module eeseq_cnt #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [LEN_W-1:0] cnt_q;

    // Hold the number of bytes still to move after the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);
endmodule

// File: rtl/eeseq_wait.sv
// Programming-time timer: after start, busy stays high for CYCLES cycles.
// Assumes: CYCLES >= 1; start only arrives while the timer is idle.
module eeseq_wait #(
    parameter int CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Count down the programming interval once started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/eeseq_top.sv
// Serial EEPROM transaction sequencer. Turns one write / addressed read /
// current-address read request into byte-engine commands, handles slave
// NACK (stop + error) and arbitration loss (abort, no stop), and holds off
// new requests for the programming time after a successful write.
// Assumes: the engine answers every issued command with one eng_done pulse
// at least one cycle later; wr_data holds the next write byte when popped.
module eeseq_top #(
    parameter int ADDR_W      = 10,
    parameter int MAX_LEN     = 16,
    parameter int WAIT_CYCLES = 5_000_000,
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int BLK_W  = ADDR_W - 8,
    localparam int CHIP_W = 3 - BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CHIP_W-1:0] req_chip,
    input  logic [7:0]        wr_data,
    output logic              wr_pop,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic [2:0]        err,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_cmd,
    output logic [7:0]        eng_tx,
    output logic              eng_last,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_arb_lost,
    input  logic [7:0]        eng_rx
);
    import eeseq_pkg::*;

    seq_state_t        state_q, state_d;
    logic [2:0]        err_q, err_d;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CHIP_W-1:0] chip_q;
    logic              issued_q;
    logic              accept, step, cmd_state;
    logic              cnt_zero, cnt_dec, rd_take;
    logic              wait_busy, wait_start;
    logic [7:0]        ctrl_wr, ctrl_rd;

    eeseq_ctrl #(.CHIP_W(CHIP_W), .BLK_W(BLK_W)) u_ctrl (
        .chip    (chip_q),
        .blk     (addr_q[ADDR_W-1:8]),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd)
    );

    eeseq_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (req_len),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    eeseq_wait #(.CYCLES(WAIT_CYCLES)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wait_start),
        .busy  (wait_busy)
    );

    assign req_ready  = (state_q == S_IDLE);
    assign accept     = req_valid && req_ready;
    assign step       = eng_done && issued_q;
    assign done       = (state_q == S_FIN);
    assign err        = err_q;
    assign wait_start = (state_q == S_FIN) && (op_q == OP_WRITE) && (err_q == ERR_NONE);

    // Decode which states talk to the engine, and what they send.
    always_comb begin
        cmd_state = 1'b1;
        eng_cmd   = CMD_WRITE;
        eng_tx    = 8'h00;
        case (state_q)
            S_START, S_RSTART: eng_cmd = CMD_START;
            S_CTRL_W:          eng_tx  = ctrl_wr;
            S_CTRL_R:          eng_tx  = ctrl_rd;
            S_WADDR:           eng_tx  = addr_q[7:0];
            S_WDATA:           eng_tx  = wr_data;
            S_RDATA:           eng_cmd = CMD_READ;
            S_STOP:            eng_cmd = CMD_STOP;
            default:           cmd_state = 1'b0;
        endcase
    end

    assign eng_cmd_valid = cmd_state && !issued_q;
    assign eng_last      = (state_q == S_RDATA) && cnt_zero;
    assign wr_pop        = eng_cmd_valid && (state_q == S_WDATA);

    // Next-state and error decisions on each engine completion.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        cnt_dec = 1'b0;
        rd_take = 1'b0;
        case (state_q)
            S_IDLE: if (req_valid) begin
                state_d = S_START;
                err_d   = ERR_NONE;
            end
            S_FIN:  state_d = wait_start ? S_WAIT : S_IDLE;
            S_WAIT: if (!wait_busy) state_d = S_IDLE;
            default: if (step) begin
                if (eng_arb_lost && state_q != S_STOP) begin
                    state_d = S_FIN;
                    err_d   = ERR_ARB;
                end else begin
                    case (state_q)
                        S_START:  state_d = (op_q == OP_READ_CUR) ? S_CTRL_R : S_CTRL_W;
                        S_RSTART: state_d = S_CTRL_R;
                        S_CTRL_W: begin
                            if (eng_nack) begin
                                err_d = ERR_NACK_CTRL; state_d = S_STOP;
                            end else state_d = S_WADDR;
                        end
                        S_WADDR: begin
                            if (eng_nack) begin
                                err_d = ERR_NACK_WADDR; state_d = S_STOP;
                            end else state_d = (op_q == OP_WRITE) ? S_WDATA : S_RSTART;
                        end
                        S_WDATA: begin
                            if (eng_nack) begin
                                err_d = ERR_NACK_DATA; state_d = S_STOP;
                            end else if (cnt_zero) state_d = S_STOP;
                            else cnt_dec = 1'b1;
                        end
                        S_CTRL_R: begin
                            if (eng_nack) begin
                                err_d = ERR_NACK_CTRL; state_d = S_STOP;
                            end else state_d = S_RDATA;
                        end
                        S_RDATA: begin
                            rd_take = 1'b1;
                            if (cnt_zero) state_d = S_STOP;
                            else cnt_dec = 1'b1;
                        end
                        S_STOP:  state_d = S_FIN;
                        default: state_d = S_IDLE;
                    endcase
                end
            end
        endcase
    end

    // Sequencer state, error code and issued-command flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            err_q    <= ERR_NONE;
            issued_q <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (step)               issued_q <= 1'b0;
            else if (eng_cmd_valid) issued_q <= 1'b1;
        end
    end

    // Capture the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_WRITE;
            addr_q <= '0;
            chip_q <= '0;
        end else if (accept) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            chip_q <= req_chip;
        end
    end

    // Register each received byte out to the client.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= rd_take;
            if (rd_take) rd_data <= eng_rx;
        end
    end

    p_single_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |=> !eng_cmd_valid);
    p_pop_is_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> (eng_cmd_valid && eng_cmd == CMD_WRITE));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_rd_not_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !done);
    p_wait_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_busy |-> !req_ready);
    p_last_only_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_valid && eng_last) |-> (eng_cmd == CMD_READ));
endmodule

// File: tb/eeseq_top_test.sv
// Scoreboard bench: a mock byte engine with an EEPROM model answers commands;
// the driver pushes expected read bytes, a monitor pops and compares them.
module eeseq_top_test;
    localparam int ADDR_W = 10;
    localparam int WAITC  = 40;
    localparam logic [0:0] CHIP = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [7:0]  wr_data;
    logic        wr_pop;
    logic [7:0]  rd_data;
    logic        rd_valid, done;
    logic [2:0]  err;
    logic        eng_cmd_valid;
    logic [1:0]  eng_cmd;
    logic [7:0]  eng_tx;
    logic        eng_last;
    logic        eng_done = 1'b0, eng_nack = 1'b0, eng_arb_lost = 1'b0;
    logic [7:0]  eng_rx = 8'h00;

    eeseq_top #(.ADDR_W(ADDR_W), .MAX_LEN(16), .WAIT_CYCLES(WAITC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_chip(CHIP),
        .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .err(err), .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
        .eng_tx(eng_tx), .eng_last(eng_last), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .eng_rx(eng_rx)
    );

    // driver-owned configuration
    int         txn_id = 0;
    int         nack_at = -1;
    int         arb_at = -1;
    logic [7:0] wdat [16];
    logic [7:0] ref_mem [1024];
    logic [7:0] exp_q [$];
    int         n_checks = 0, n_fail = 0;

    // mock-owned state and per-transaction log
    logic [7:0] mem [1024];
    int seen_id = 0, pend = 0, cmd_no = 0, byte_idx = 0, fifo_rd = 0;
    int n_start = 0, n_stop = 0, n_wr = 0, n_rd = 0, last_cnt = 0, last_idx = 0;
    logic [1:0] last_cmd = 2'd0;
    logic [7:0] ctrl0 = 8'h00, ctrl1 = 8'h00;
    logic dir_rd = 1'b0, r_nack = 1'b0, r_arb = 1'b0;
    logic [7:0] r_rx = 8'h00;
    logic [9:0] ptr = '0;

    assign wr_data = wdat[fifo_rd[3:0]];

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 16; i++) wdat[i] = 8'h00;
    end

    // Mock byte engine and slave model, acting away from the active edge.
    always @(negedge clk) begin
        if (txn_id != seen_id) begin
            seen_id = txn_id; cmd_no = 0; fifo_rd = 0; n_start = 0; n_stop = 0;
            n_wr = 0; n_rd = 0; last_cnt = 0; last_idx = 0; ctrl0 = 0; ctrl1 = 0;
        end
        eng_done = 1'b0; eng_nack = 1'b0; eng_arb_lost = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                eng_done = 1'b1; eng_nack = r_nack; eng_arb_lost = r_arb; eng_rx = r_rx;
            end
        end
        if (rst_n && eng_cmd_valid) begin
            cmd_no++;
            last_cmd = eng_cmd;
            r_nack = 1'b0; r_rx = 8'h00; pend = 2;
            r_arb = (cmd_no == arb_at);
            case (eng_cmd)
                2'd0: begin n_start++; byte_idx = 0; end
                2'd1: begin
                    n_wr++;
                    if (byte_idx == 0) begin
                        if (n_start <= 1 && ctrl0 == 8'h00) ctrl0 = eng_tx; else ctrl1 = eng_tx;
                        dir_rd = eng_tx[0];
                        if (eng_tx[7:4] != 4'hA || eng_tx[3] != CHIP[0]) r_nack = 1'b1;
                    end
                    if (byte_idx == nack_at) r_nack = 1'b1;
                    if (!r_arb && !r_nack) begin
                        if (byte_idx == 1 && !dir_rd) ptr = {ctrl0[2:1], eng_tx};
                        else if (byte_idx >= 2 && !dir_rd) begin
                            mem[ptr] = eng_tx;
                            ptr[3:0] = ptr[3:0] + 4'd1;
                        end
                    end
                    byte_idx++;
                end
                2'd2: begin
                    n_rd++;
                    r_rx = mem[ptr];
                    ptr = ptr + 10'd1;
                    if (eng_last) begin last_cnt++; last_idx = n_rd; end
                end
                default: n_stop++;
            endcase
            if (wr_pop) fifo_rd++;
        end
    end

    // Monitor: compare each delivered read byte with the scoreboard queue.
    int mon_checks = 0, mon_fail = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_fail++;
                $display("FAIL R3: unexpected read byte act=%02h exp=none", rd_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    mon_fail++;
                    $display("FAIL R3: read data act=%02h exp=%02h", rd_data, e);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    int gap;
    int cur_ptr = 0;

    // Driver: issue one request, wait for done, measure the ready gap.
    task automatic run(input logic [1:0] op, input int addr, input int n,
                       input int nk, input int ab, input logic [2:0] exp_err);
        while (!req_ready) @(negedge clk);
        nack_at = nk; arb_at = ab;
        for (int i = 0; i < 16; i++) wdat[i] = 8'((8'h5A ^ (i * 29)) + addr);
        if (op != 2'd0 && exp_err == 3'd0) begin
            int base;
            base = (op == 2'd1) ? cur_ptr : addr;
            for (int i = 0; i < n; i++) exp_q.push_back(ref_mem[(base + i) % 1024]);
            cur_ptr = (base + n) % 1024;
        end
        if (op == 2'd0 && exp_err == 3'd0) begin
            for (int i = 0; i < n; i++)
                ref_mem[(addr & 10'h3F0) | ((addr + i) & 15)] = wdat[i];
        end
        txn_id++;
        req_op = op; req_addr = 10'(addr); req_len = 4'(n - 1); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(err == exp_err, "R6/R7 err code", int'(err), int'(exp_err));
        gap = 0;
        @(negedge clk);
        while (!req_ready) begin gap++; @(negedge clk); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
        chk(eng_cmd_valid == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R9 idle outputs",
            int'({eng_cmd_valid, done, rd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);

        // page write, block 2
        run(2'd0, 10'h2A3, 4, -1, -1, 3'd0);
        chk(ctrl0 == 8'hAC, "R1 write ctrl byte", int'(ctrl0), 8'hAC);
        chk(n_start == 1 && n_stop == 1 && n_wr == 6, "R2 write command count", n_wr, 6);
        chk(fifo_rd == 4, "R2 FIFO pops", fifo_rd, 4);
        chk(mem[10'h2A3] == ref_mem[10'h2A3] && mem[10'h2A6] == ref_mem[10'h2A6],
            "R2 written data", int'(mem[10'h2A6]), int'(ref_mem[10'h2A6]));
        chk(gap >= WAITC && gap <= WAITC + 2, "R8 write wait", gap, WAITC + 1);

        // byte write, block 0
        run(2'd0, 10'h015, 1, -1, -1, 3'd0);
        chk(ctrl0 == 8'hA8 && mem[10'h015] == ref_mem[10'h015], "R2 byte write",
            int'(mem[10'h015]), int'(ref_mem[10'h015]));
        chk(gap >= WAITC, "R8 byte write wait", gap, WAITC + 1);

        // addressed read 4 bytes
        run(2'd2, 10'h2A3, 4, -1, -1, 3'd0);
        chk(n_start == 2 && ctrl1 == 8'hAD, "R3 repeated start + R1 read ctrl", int'(ctrl1), 8'hAD);
        chk(last_cnt == 1 && last_idx == 4, "R5 NACK on last of 4", last_idx, 4);
        chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
        chk(gap == 0, "R8 no wait after read", gap, 0);

        // addressed read single byte
        run(2'd2, 10'h015, 1, -1, -1, 3'd0);
        chk(last_cnt == 1 && last_idx == 1, "R5 NACK on single read", last_idx, 1);

        // current-address read
        run(2'd1, 0, 3, -1, -1, 3'd0);
        chk(n_start == 1 && n_wr == 1 && ctrl0 == 8'hA9, "R4 current read sequence", n_wr, 1);
        chk(exp_q.size() == 0 && n_rd == 3, "R4 current read bytes", n_rd, 3);

        // NACK on control byte
        run(2'd0, 10'h300, 2, 0, -1, 3'd1);
        chk(n_wr == 1 && last_cmd == 2'd3 && n_stop == 1, "R6 stop after ctrl NACK", n_wr, 1);
        chk(gap == 0, "R8 no wait after failed write", gap, 0);

        // NACK on word address
        run(2'd0, 10'h300, 2, 1, -1, 3'd2);
        chk(n_wr == 2 && last_cmd == 2'd3, "R6 stop after address NACK", n_wr, 2);

        // NACK on second data byte
        run(2'd0, 10'h040, 4, 3, -1, 3'd3);
        chk(n_wr == 4 && fifo_rd == 2 && last_cmd == 2'd3, "R6 stop after data NACK", fifo_rd, 2);

        // arbitration lost on write control byte
        run(2'd0, 10'h050, 2, -1, 2, 3'd4);
        chk(n_stop == 0 && last_cmd == 2'd1 && cmd_no == 2, "R7 no stop after arb loss", cmd_no, 2);

        // long sequential read, full length
        run(2'd2, 10'h100, 16, -1, -1, 3'd0);
        chk(n_rd == 16 && last_idx == 16 && last_cnt == 1, "R5 NACK on 16th", last_idx, 16);
        chk(exp_q.size() == 0, "R3 16 bytes delivered", exp_q.size(), 0);

        // current read with NACK on control byte
        run(2'd1, 0, 2, 0, -1, 3'd1);
        chk(n_rd == 0 && n_stop == 1, "R6 read ctrl NACK", n_rd, 0);

        // arbitration lost on first read byte
        run(2'd2, 10'h100, 3, -1, 6, 3'd4);
        chk(n_rd == 1 && n_stop == 0 && cmd_no == 6, "R7 abort during read", cmd_no, 6);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 no byte after arb loss", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks + mon_checks, n_fail + mon_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks + mon_checks + 1, n_fail + mon_fail + 1);
        $finish;
    end
endmodule